// File: doc/BRIEF.md
# Card Status-Change Event Register

This block holds four sticky event flags that a card raises from external event lines and that a host reads and acknowledges over a simple synchronous register bus. Each event line is first brought into the register clock domain by a two-flop synchroniser. The synchronised level then sets its flag. The flag stays set until the host writes a 1 to its bit position.

Two enable inputs come from a neighbouring configuration register. The packet-event enable gates the three upper flags, and the ring-event enable gates the lowest flag. The enabled flags are ORed into a single `changed` indication. When the host has also set the arm input, which comes from the configuration-and-status register, that indication pulls an active-low status-change pin low. Both outputs are combinational from the stored flags and the control inputs.

Each flag is a two-state machine with states `EV_CLEAR` and `EV_HELD`:
- The `capture` transition (`EV_CLEAR` to `EV_HELD`) fires when the synchronised input is high.
- The `release` transition (`EV_HELD` to `EV_CLEAR`) fires on a host write-1 to the flag's bit, provided the synchronised input is low in that cycle.
- Otherwise the flag keeps its state (`idle` in `EV_CLEAR`, `hold` in `EV_HELD`).

Top module: `card_evt_reg`

## Requirements
- R1: The register answers only at bus address 0x1F. A read at any other address returns 0x00, and a write at any other address leaves every flag unchanged.
- R2: Read-data bit positions map as follows: `evt_in[3]` to bit 7, `evt_in[2]` to bit 6, `evt_in[1]` (packet received) to bit 5, and `evt_in[0]` (ring indicate) to bit 4. An input that goes high is seen in read data after exactly the third rising clock edge, and not after the second. A high pulse lasting one clock period is captured.
- R3: A set flag stays 1 after its input returns low, until the host clears it.
- R4: Writing 1 to bit 4, 5, 6 or 7 at address 0x1F clears that flag. Writing 0 to a bit leaves that flag unchanged.
- R5: If the synchronised input is high in the same cycle as a write-1 clear of its flag, the flag stays 1.
- R6: Bits 3 to 0 always read as 0, and writes to those bits have no effect on any flag.
- R7: `changed_flag` is 1 exactly when (bit 7, 6 or 5 is set and `pkt_evt_en` is 1) or (bit 4 is set and `ring_evt_en` is 1). It follows its inputs with no clock of latency.
- R8: `stschg_n` is 0 exactly when `changed_flag` is 1 and `sig_chg_arm` is 1, and 1 otherwise. It has no clock of latency.
- R9: A synchronous reset (`rst` high at a rising edge) clears all flags and the synchronisers, so `stschg_n` reads 1 and read data reads 0x00 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 8 | Register bus address |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data; a 1 in bits 7..4 clears that flag |
| bus_rdata | output | 8 | Combinational read data |
| evt_in | input | 4 | Asynchronous event lines, index 3 down to 0 map to bits 7 down to 4 |
| pkt_evt_en | input | 1 | Enable for flags at bits 7, 6 and 5 |
| ring_evt_en | input | 1 | Enable for the flag at bit 4 |
| sig_chg_arm | input | 1 | Host arm bit for the status-change pin |
| changed_flag | output | 1 | OR of the enabled flags |
| stschg_n | output | 1 | Active-low status-change output |

## Verification
An event input raised just after a falling edge appears in read data after the third rising edge that follows. The bench therefore samples after the second edge, where it expects 0, and after the third, where it expects 1. A bus write takes effect on the single rising edge while the strobe is high, so each clear or ignored write is judged at the next falling edge. The enable, arm and address inputs act with no latency, so they are changed at a falling edge and the outputs are sampled a nanosecond later, within the same half period.

// File: rtl/card_evt_pkg.sv
package card_evt_pkg;
    localparam int EVT_COUNT   = 4;
    localparam int BUS_AW      = 8;
    localparam int BUS_DW      = 8;
    localparam int EVT_BASE    = 4;
    localparam int RING_GROUP  = 1;
    localparam logic [7:0] EVT_REG_ADDR = 8'h1F;

    typedef enum logic {
        EV_CLEAR = 1'b0,
        EV_HELD  = 1'b1
    } ev_state_t;
endpackage

// File: rtl/card_evt_sync.sv
module card_evt_sync #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    for (genvar g = 0; g < WIDTH; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                stage1_q[g] <= 1'b0;
                stage2_q[g] <= 1'b0;
            end else begin
                stage1_q[g] <= d_i[g];
                stage2_q[g] <= stage1_q[g];
            end
        end
    end

    assign q_o = stage2_q;

    // Counts clean edges since reset so the two-deep check never looks before reset.
    logic [1:0] warm_cnt;
    always_ff @(posedge clk) begin
        if (rst)                 warm_cnt <= 2'd0;
        else if (warm_cnt != 2'd2) warm_cnt <= warm_cnt + 2'd1;
    end

    // R2: the output is the input delayed by two clock edges.
    a_r2_two_stage: assert property (@(posedge clk) disable iff (rst)
        (warm_cnt == 2'd2) |-> (q_o == $past(d_i, 2)));
endmodule

// File: rtl/card_evt_flag.sv
module card_evt_flag
    import card_evt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic held_o
);
    ev_state_t state_q;
    ev_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EV_CLEAR: if (set_i) state_d = EV_HELD;                 // capture
            EV_HELD:  if (clr_i && !set_i) state_d = EV_CLEAR;      // release
            default:  state_d = EV_CLEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= EV_CLEAR;
        else     state_q <= state_d;
    end

    always_comb begin
        held_o = (state_q == EV_HELD);
    end

    a_r3_sticky: assert property (@(posedge clk) disable iff (rst)
        (held_o && !clr_i) |=> held_o);
    a_r4_clear: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !held_o);
    a_r5_set_wins: assert property (@(posedge clk) disable iff (rst)
        set_i |=> held_o);
    a_r9_reset: assert property (@(posedge clk)
        rst |=> !held_o);
endmodule

// File: rtl/card_evt_combine.sv
module card_evt_combine #(
    parameter int WIDTH      = 4,
    parameter int RING_COUNT = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] flags_i,
    input  logic             pkt_en_i,
    input  logic             ring_en_i,
    input  logic             arm_i,
    output logic             changed_o,
    output logic             stschg_n_o
);
    logic [WIDTH-1:0] gated;

    for (genvar g = 0; g < WIDTH; g++) begin : g_gate
        if (g < RING_COUNT) begin : g_ring
            assign gated[g] = flags_i[g] & ring_en_i;
        end else begin : g_pkt
            assign gated[g] = flags_i[g] & pkt_en_i;
        end
    end

    assign changed_o  = |gated;
    assign stschg_n_o = ~(changed_o & arm_i);

    a_r7_needs_flag: assert property (@(posedge clk) disable iff (rst)
        changed_o |-> (|flags_i));
    a_r7_all_masked: assert property (@(posedge clk) disable iff (rst)
        (!pkt_en_i && !ring_en_i) |-> !changed_o);
    a_r8_disarmed: assert property (@(posedge clk) disable iff (rst)
        !arm_i |-> stschg_n_o);
    a_r8_low_needs_changed: assert property (@(posedge clk) disable iff (rst)
        !stschg_n_o |-> changed_o);
endmodule

// File: rtl/card_evt_reg.sv
module card_evt_reg
    import card_evt_pkg::*;
#(
    parameter int ADDR_W     = BUS_AW,
    parameter int DATA_W     = BUS_DW,
    parameter int N_EVT      = EVT_COUNT,
    parameter int FLAG_LSB   = EVT_BASE,
    parameter int N_RING     = RING_GROUP,
    parameter logic [ADDR_W-1:0] REG_ADDR = EVT_REG_ADDR
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N_EVT-1:0]  evt_in,
    input  logic              pkt_evt_en,
    input  logic              ring_evt_en,
    input  logic              sig_chg_arm,
    output logic              changed_flag,
    output logic              stschg_n
);
    localparam int FLAG_MSB = FLAG_LSB + N_EVT - 1;

    logic             hit;
    logic [N_EVT-1:0] evt_sync;
    logic [N_EVT-1:0] clr_req;
    logic [N_EVT-1:0] flags;
    logic             unused_wdata;

    assign hit          = (bus_addr == REG_ADDR);
    assign unused_wdata = ^bus_wdata[FLAG_LSB-1:0];

    card_evt_sync #(.WIDTH(N_EVT)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (evt_in),
        .q_o (evt_sync)
    );

    for (genvar g = 0; g < N_EVT; g++) begin : g_flag
        assign clr_req[g] = bus_wr & hit & bus_wdata[FLAG_LSB + g];
        card_evt_flag u_flag (
            .clk    (clk),
            .rst    (rst),
            .set_i  (evt_sync[g]),
            .clr_i  (clr_req[g]),
            .held_o (flags[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (hit) bus_rdata[FLAG_MSB:FLAG_LSB] = flags;
    end

    card_evt_combine #(.WIDTH(N_EVT), .RING_COUNT(N_RING)) u_comb (
        .clk        (clk),
        .rst        (rst),
        .flags_i    (flags),
        .pkt_en_i   (pkt_evt_en),
        .ring_en_i  (ring_evt_en),
        .arm_i      (sig_chg_arm),
        .changed_o  (changed_flag),
        .stschg_n_o (stschg_n)
    );

    // R1: a write elsewhere never drops a flag that has no clear of its own.
    a_r1_other_addr: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !hit && (|flags)) |=> (|flags));
    // R9: reset leaves the pin released.
    a_r9_pin_high: assert property (@(posedge clk)
        rst |=> stschg_n);
endmodule

// File: tb/card_evt_reg_tb.sv
`timescale 1ns/1ps
module card_evt_reg_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] bus_addr = 8'h1F;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [3:0] evt_in = 4'h0;
    logic       pkt_evt_en = 1'b0;
    logic       ring_evt_en = 1'b0;
    logic       sig_chg_arm = 1'b0;
    logic       changed_flag;
    logic       stschg_n;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    card_evt_reg dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in),
        .pkt_evt_en(pkt_evt_en), .ring_evt_en(ring_evt_en),
        .sig_chg_arm(sig_chg_arm), .changed_flag(changed_flag), .stschg_n(stschg_n)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd_chk(input string req, input logic [7:0] addr, input logic [7:0] exp);
        bus_addr = addr;
        #1;
        chk(req, bus_rdata, exp);
        bus_addr = 8'h1F;
    endtask

    task automatic bus_write(input logic [7:0] addr, input logic [7:0] data);
        @(negedge clk);
        bus_addr = addr; bus_wdata = data; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 8'h1F; bus_wdata = 8'h00;
    endtask

    task automatic raise(input logic [3:0] mask);
        @(negedge clk);
        evt_in = mask;
        @(negedge clk);
        evt_in = 4'h0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset_state();
        chk("R9 reset rdata", bus_rdata, 8'h00);
        chk("R9 reset pin", {7'd0, stschg_n}, 8'h01);
        chk("R7 reset changed", {7'd0, changed_flag}, 8'h00);
    endtask

    task automatic t_capture();
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            evt_in[i] = 1'b1;
            @(negedge clk);
            evt_in[i] = 1'b0;
            @(negedge clk);
            rd_chk("R2 not before third edge", 8'h1F, 8'h00);
            @(negedge clk);
            rd_chk("R2 bit position", 8'h1F, 8'h10 << i);
            repeat (5) @(negedge clk);
            rd_chk("R3 sticky after input low", 8'h1F, 8'h10 << i);
            bus_write(8'h1F, 8'h10 << i);
            rd_chk("R4 write-1 clears", 8'h1F, 8'h00);
        end
    endtask

    task automatic t_write_zero();
        raise(4'b1001);
        rd_chk("R2 two bits", 8'h1F, 8'h90);
        bus_write(8'h1F, 8'h00);
        rd_chk("R4 write-0 no effect", 8'h1F, 8'h90);
        bus_write(8'h1F, 8'h6F);
        rd_chk("R6 reserved write ignored", 8'h1F, 8'h90);
        bus_write(8'h1F, 8'h80);
        rd_chk("R4 partial clear", 8'h1F, 8'h10);
        bus_write(8'h1F, 8'h10);
        rd_chk("R4 final clear", 8'h1F, 8'h00);
    endtask

    task automatic t_address();
        raise(4'b0010);
        rd_chk("R1 other addr reads zero", 8'h1E, 8'h00);
        bus_write(8'h1E, 8'hFF);
        rd_chk("R1 other addr write ignored", 8'h1F, 8'h20);
        bus_write(8'h3F, 8'hFF);
        rd_chk("R1 other addr write ignored 2", 8'h1F, 8'h20);
        bus_write(8'h1F, 8'hFF);
        rd_chk("R1 own addr clear", 8'h1F, 8'h00);
    endtask

    task automatic t_set_wins();
        @(negedge clk);
        evt_in[2] = 1'b1;
        repeat (4) @(negedge clk);
        bus_write(8'h1F, 8'h40);
        rd_chk("R5 set wins over clear", 8'h1F, 8'h40);
        evt_in[2] = 1'b0;
        repeat (2) @(negedge clk);
        bus_write(8'h1F, 8'h40);
        rd_chk("R4 clear after input low", 8'h1F, 8'h00);
    endtask

    task automatic t_changed();
        raise(4'b0001);
        pkt_evt_en = 1'b1; ring_evt_en = 1'b0; sig_chg_arm = 1'b1;
        #1 chk("R7 ring flag masked by ring enable", {7'd0, changed_flag}, 8'h00);
        chk("R8 pin high when no change", {7'd0, stschg_n}, 8'h01);
        @(negedge clk); ring_evt_en = 1'b1;
        #1 chk("R7 ring flag enabled", {7'd0, changed_flag}, 8'h01);
        chk("R8 pin low when armed", {7'd0, stschg_n}, 8'h00);
        @(negedge clk); sig_chg_arm = 1'b0;
        #1 chk("R8 pin high when disarmed", {7'd0, stschg_n}, 8'h01);
        bus_write(8'h1F, 8'h10);
        raise(4'b0100);
        pkt_evt_en = 1'b0; sig_chg_arm = 1'b1;
        #1 chk("R7 packet group masked", {7'd0, changed_flag}, 8'h00);
        @(negedge clk); pkt_evt_en = 1'b1;
        #1 chk("R7 packet group enabled", {7'd0, changed_flag}, 8'h01);
        chk("R8 pin low on packet group", {7'd0, stschg_n}, 8'h00);
        bus_write(8'h1F, 8'h40);
        chk("R7 changed drops after clear", {7'd0, changed_flag}, 8'h00);
        chk("R8 pin released after clear", {7'd0, stschg_n}, 8'h01);
    endtask

    task automatic t_reset_mid();
        raise(4'b1111);
        rd_chk("R2 all bits", 8'h1F, 8'hF0);
        @(negedge clk); evt_in = 4'hF; rst = 1'b1;
        @(negedge clk); rst = 1'b0; evt_in = 4'h0;
        rd_chk("R9 reset clears flags", 8'h1F, 8'h00);
        chk("R9 reset releases pin", {7'd0, stschg_n}, 8'h01);
        repeat (3) @(negedge clk);
        rd_chk("R9 synchronisers cleared", 8'h1F, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        t_capture();
        t_write_zero();
        t_address();
        t_set_wins();
        t_changed();
        t_reset_mid();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule